// File: doc/BRIEF.md
# Masked Highest-Priority Interrupt Selector

This block sits between a set of interrupt sources and one processor. Each cycle it looks at every source that is pending, finds the most urgent one, and decides whether that one may interrupt the processor now. A source carries an 8-bit priority, where a smaller value is more urgent, a group tag and a non-maskable flag. A per-group split point divides each priority into a coarse group priority and a fine subpriority.

Three comparisons are applied to the winner. First, a programmable threshold uses the whole 8-bit priority. Second, the running priority, supplied by the acknowledge/completion tracker, is compared against the group priority only. Third, a small two-state machine (`ST_QUIET`, `ST_RAISE`) holds the request line. The machine moves from `ST_QUIET` to `ST_RAISE` when the winner has sufficient priority. It moves from `ST_RAISE` back to `ST_QUIET` when the winner no longer has sufficient priority. The winner's ID and priority are registered next to the request.

Top module: `irq_pick`

## Requirements
- R1: Among eligible sources, a non-maskable source outranks any maskable one. After that the lower group priority wins, then the lower full 8-bit priority (the subpriority decides within a group), then the lower source ID.
- R2: A maskable winner raises `irq_req_o` only if its full priority is numerically below the threshold. The split point is never applied to this comparison.
- R3: The threshold resets to 0x00, so after reset no maskable source raises a request.
- R4: A non-maskable winner ignores the threshold.
- R5: A maskable winner raises a request only if its group priority is strictly below `run_prio_i`. An equal group priority never raises a request, whatever the subpriority.
- R6: A non-maskable winner raises a request if its group priority is below `run_prio_i`. It also raises one if the two are equal and the `nmi_act_i` bit of its group is 0. It never raises one otherwise.
- R7: For split value N (3-bit field `N` of group g at `bpr_i[3g+2:3g]`), the group priority is the priority with bits [N:0] cleared, so bits [7:N+1] remain. N=7 gives group priority 0.
- R8: Only the single winner is judged. When that winner lacks sufficient priority, `irq_req_o` is 0 even if a lower-ranked source would pass. With nothing eligible, `win_valid_o`=0, `win_id_o`=0 and `win_prio_o`=0xFF.
- R9: All outputs follow the source inputs with exactly one clock of latency. A threshold write (`mask_we_i`) reaches the outputs on the second rising edge after it is applied.
- R10: A source whose group tag is NUM_GRP or greater is not eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_IRQ | Pending-and-enabled flag per source |
| prio_i | input | NUM_IRQ*8 | Priority per source, source k at [8k+7:8k] |
| grp_i | input | NUM_IRQ*GRP_W | Group tag per source |
| nmi_i | input | NUM_IRQ | Non-maskable flag per source |
| bpr_i | input | NUM_GRP*3 | Split point per group |
| nmi_act_i | input | NUM_GRP | Non-maskable source already active, per group |
| run_prio_i | input | 8 | Running priority (0xFF when idle) |
| mask_we_i | input | 1 | Threshold write strobe |
| mask_wdata_i | input | 8 | Threshold write value |
| irq_req_o | output | 1 | Interrupt request to the processor |
| win_valid_o | output | 1 | A winner exists |
| win_id_o | output | ID_W | Winning source ID |
| win_prio_o | output | 8 | Winning source priority |

## Verification
The bench looks for mixing up the three comparisons. A design that applied the split point to the threshold, or the full priority to preemption, would let an equal-group source preempt or would mask a source with the wrong value. It also builds cross-group cases in which a larger full priority wins on group priority. A plain comparator would pick the wrong ID there. Further cases cover the equal-group non-maskable rule, a blocked winner hiding a passing loser, out-of-range tags and the one-cycle latency, each of which exposes a broken tie-break or a premature request.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PRIO_W = 8;
    localparam int BP_W   = 3;
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_RAISE = 1'b1
    } req_state_e;

    // Keep bits [PRIO_W-1:bp+1] of a priority: the group priority.
    function automatic logic [PRIO_W-1:0] group_part(input logic [PRIO_W-1:0] p,
                                                     input logic [BP_W-1:0]   bp);
        logic [PRIO_W:0] keep;
        keep = {(PRIO_W+1){1'b1}} << (int'(bp) + 1);
        return p & keep[PRIO_W-1:0];
    endfunction
endpackage

// File: rtl/irq_rank_tree.sv
module irq_rank_tree
    import irq_pick_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int NUM_GRP = 3,
    localparam int ID_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [NUM_IRQ*GRP_W-1:0]  grp_i,
    input  logic [NUM_IRQ-1:0]        nmi_i,
    input  logic [NUM_GRP*BP_W-1:0]   bpr_i,
    output logic                      best_valid_o,
    output logic                      best_nmi_o,
    output logic [ID_W-1:0]           best_id_o,
    output logic [PRIO_W-1:0]         best_prio_o,
    output logic [PRIO_W-1:0]         best_gp_o,
    output logic [GRP_W-1:0]          best_grp_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LEAVES = 1 << $clog2(NUM_IRQ);
    localparam int NODES  = 2 * LEAVES - 1;

    typedef struct packed {
        logic              valid;
        logic              nmi;
        logic [PRIO_W-1:0] gp;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
        logic [GRP_W-1:0]  grp;
    } cand_t;

    cand_t leaf_c [LEAVES];

    // Operand a always covers the lower IDs, so a full tie keeps a.
    function automatic cand_t pick(input cand_t a, input cand_t b);
        if (!b.valid)           return a;
        if (!a.valid)           return b;
        if (a.nmi != b.nmi)     return a.nmi ? a : b;
        if (a.gp != b.gp)       return (a.gp < b.gp) ? a : b;
        if (a.prio != b.prio)   return (a.prio < b.prio) ? a : b;
        return a;
    endfunction

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < NUM_IRQ) begin : g_real
            logic [GRP_W-1:0]  tag;
            logic [PRIO_W-1:0] pv;
            logic [BP_W-1:0]   bp;
            logic              tag_ok;

            assign tag = grp_i[k*GRP_W +: GRP_W];
            assign pv  = prio_i[k*PRIO_W +: PRIO_W];

            always_comb begin
                bp     = '0;
                tag_ok = 1'b0;
                for (int g = 0; g < NUM_GRP; g++) begin
                    if (tag == GRP_W'(g)) begin
                        bp     = bpr_i[g*BP_W +: BP_W];
                        tag_ok = 1'b1;
                    end
                end
            end

            assign leaf_c[k] = cand_t'{valid: pend_i[k] & tag_ok,
                                       nmi:   nmi_i[k],
                                       gp:    group_part(pv, bp),
                                       prio:  pv,
                                       id:    ID_W'(k),
                                       grp:   tag};
        end else begin : g_pad
            assign leaf_c[k] = '0;
        end
    end

    cand_t root;

    always_comb begin
        cand_t work [NODES];
        for (int k = 0; k < LEAVES; k++) work[LEAVES-1+k] = leaf_c[k];
        for (int i = LEAVES - 2; i >= 0; i--) work[i] = pick(work[2*i+1], work[2*i+2]);
        root = work[0];
    end

    assign best_valid_o = root.valid;
    assign best_nmi_o   = root.nmi;
    assign best_id_o    = root.id;
    assign best_prio_o  = root.prio;
    assign best_gp_o    = root.gp;
    assign best_grp_o   = root.grp;
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pick_pkg::*;
#(
    parameter int NUM_GRP = 3,
    localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic              cand_valid_i,
    input  logic              cand_nmi_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic [PRIO_W-1:0] cand_gp_i,
    input  logic [GRP_W-1:0]  cand_grp_i,
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [PRIO_W-1:0] run_prio_i,
    input  logic [NUM_GRP-1:0] nmi_act_i,
    output logic              sufficient_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic act_bit;
    logic pass_mask;
    logic pass_run;

    always_comb begin
        act_bit = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (cand_grp_i == GRP_W'(g)) act_bit = nmi_act_i[g];
        end
    end

    always_comb begin
        // Threshold: full priority, never grouped; NMI bypasses it.
        pass_mask = cand_nmi_i | (cand_prio_i < mask_i);
        // Preemption: group priority only, strictly more urgent.
        if (cand_gp_i < run_prio_i)       pass_run = 1'b1;
        else if (cand_gp_i == run_prio_i) pass_run = cand_nmi_i & ~act_bit;
        else                              pass_run = 1'b0;
        sufficient_o = cand_valid_i & pass_mask & pass_run;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pick_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int NUM_GRP = 3,
    localparam int ID_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [NUM_IRQ*GRP_W-1:0]  grp_i,
    input  logic [NUM_IRQ-1:0]        nmi_i,
    input  logic [NUM_GRP*BP_W-1:0]   bpr_i,
    input  logic [NUM_GRP-1:0]        nmi_act_i,
    input  logic [PRIO_W-1:0]         run_prio_i,
    input  logic                      mask_we_i,
    input  logic [PRIO_W-1:0]         mask_wdata_i,
    output logic                      irq_req_o,
    output logic                      win_valid_o,
    output logic [ID_W-1:0]           win_id_o,
    output logic [PRIO_W-1:0]         win_prio_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic              cand_valid;
    logic              cand_nmi;
    logic [ID_W-1:0]   cand_id;
    logic [PRIO_W-1:0] cand_prio;
    logic [PRIO_W-1:0] cand_gp;
    logic [GRP_W-1:0]  cand_grp;
    logic              go;
    logic [PRIO_W-1:0] mask_q;
    logic [PRIO_W-1:0] win_gp_q;
    logic              win_nmi_q;
    req_state_e        state_q, state_d;

    irq_rank_tree #(.NUM_IRQ(NUM_IRQ), .NUM_GRP(NUM_GRP)) u_tree (
        .pend_i      (pend_i),
        .prio_i      (prio_i),
        .grp_i       (grp_i),
        .nmi_i       (nmi_i),
        .bpr_i       (bpr_i),
        .best_valid_o(cand_valid),
        .best_nmi_o  (cand_nmi),
        .best_id_o   (cand_id),
        .best_prio_o (cand_prio),
        .best_gp_o   (cand_gp),
        .best_grp_o  (cand_grp)
    );

    irq_gate #(.NUM_GRP(NUM_GRP)) u_gate (
        .cand_valid_i(cand_valid),
        .cand_nmi_i  (cand_nmi),
        .cand_prio_i (cand_prio),
        .cand_gp_i   (cand_gp),
        .cand_grp_i  (cand_grp),
        .mask_i      (mask_q),
        .run_prio_i  (run_prio_i),
        .nmi_act_i   (nmi_act_i),
        .sufficient_o(go)
    );

    // Threshold register; 0x00 blocks every maskable source.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (go)  state_d = ST_RAISE;
            ST_RAISE: if (!go) state_d = ST_QUIET;
            default:           state_d = ST_QUIET;
        endcase
    end

    // Output register for the winner.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_valid_o <= 1'b0;
            win_id_o    <= '0;
            win_prio_o  <= PRIO_IDLE;
            win_gp_q    <= PRIO_IDLE;
            win_nmi_q   <= 1'b0;
        end else if (cand_valid) begin
            win_valid_o <= 1'b1;
            win_id_o    <= cand_id;
            win_prio_o  <= cand_prio;
            win_gp_q    <= cand_gp;
            win_nmi_q   <= cand_nmi;
        end else begin
            win_valid_o <= 1'b0;
            win_id_o    <= '0;
            win_prio_o  <= PRIO_IDLE;
            win_gp_q    <= PRIO_IDLE;
            win_nmi_q   <= 1'b0;
        end
    end

    assign irq_req_o = (state_q == ST_RAISE);

    AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> pend_i[cand_id]); // R1
    AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !win_nmi_q) |-> (win_prio_o < $past(mask_q))); // R2
    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !win_nmi_q) |-> (win_gp_q < $past(run_prio_i))); // R5
    AST_NMI_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && win_nmi_q) |-> (win_gp_q <= $past(run_prio_i))); // R6
    AST_REQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> win_valid_o); // R8
endmodule

// File: tb/sim_irq_pick.sv
module sim_irq_pick;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 8;
    localparam int G  = 3;
    localparam int GW = 2;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   pend = '0;
    logic [N*8-1:0] prio = '0;
    logic [N*GW-1:0] grp = '0;
    logic [N-1:0]   nmi = '0;
    logic [G*3-1:0] bpr = '0;
    logic [G-1:0]   nact = '0;
    logic [7:0]     run = 8'hFF;
    logic           mask_we = 1'b0;
    logic [7:0]     mask_in = '0;
    logic           irq, wv;
    logic [IW-1:0]  wid;
    logic [7:0]     wprio;

    int checks = 0;
    int fails = 0;
    logic [7:0] mask_model = 8'h00;

    always #2.5 clk = ~clk; // 200 MHz

    irq_pick #(.NUM_IRQ(N), .NUM_GRP(G)) u0 (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio), .grp_i(grp),
        .nmi_i(nmi), .bpr_i(bpr), .nmi_act_i(nact), .run_prio_i(run),
        .mask_we_i(mask_we), .mask_wdata_i(mask_in),
        .irq_req_o(irq), .win_valid_o(wv), .win_id_o(wid), .win_prio_o(wprio)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gpart(input logic [7:0] p, input int n);
        logic [8:0] low;
        low = (9'd1 << (n + 1)) - 9'd1;
        return p & ~low[7:0];
    endfunction

    // Reference model built from R1, R2, R4..R8, R10.
    function automatic void model(output logic ev, output logic [IW-1:0] eid,
                                  output logic [7:0] ep, output logic eirq);
        int best = -1;
        logic [7:0] bgp = 0;
        logic [7:0] bp = 0;
        logic bn = 0;
        for (int k = 0; k < N; k++) begin
            int t = int'(grp[k*GW +: GW]);
            logic [7:0] p = prio[k*8 +: 8];
            logic [7:0] g;
            logic better;
            if (!pend[k] || t >= G) continue;
            g = gpart(p, int'(bpr[t*3 +: 3]));
            if (best < 0) better = 1;
            else if (nmi[k] != bn) better = nmi[k];
            else if (g != bgp) better = (g < bgp);
            else better = (p < bp);
            if (better) begin best = k; bgp = g; bp = p; bn = nmi[k]; end
        end
        ev = (best >= 0);
        eid = ev ? IW'(best) : '0;
        ep = ev ? bp : 8'hFF;
        eirq = 0;
        if (ev) begin
            int t = int'(grp[best*GW +: GW]);
            logic okm = bn || (bp < mask_model);
            logic okr = (bgp < run) || (bn && bgp == run && !nact[t]);
            eirq = okm && okr;
        end
    endfunction

    task automatic step_model(input string req);
        logic ev, eirq;
        logic [IW-1:0] eid;
        logic [7:0] ep;
        @(negedge clk);
        model(ev, eid, ep, eirq);
        chk(req, "valid", 32'(wv), 32'(ev));
        chk(req, "id", 32'(wid), 32'(eid));
        chk(req, "prio", 32'(wprio), 32'(ep));
        chk(req, "irq", 32'(irq), 32'(eirq));
    endtask

    task automatic set_mask(input logic [7:0] v);
        mask_in = v;
        mask_we = 1'b1;
        @(negedge clk);
        mask_we = 1'b0;
        mask_model = v;
    endtask

    task automatic put(input int k, input logic [7:0] p, input int g, input logic n);
        pend[k] = 1'b1;
        prio[k*8 +: 8] = p;
        grp[k*GW +: GW] = GW'(g);
        nmi[k] = n;
    endtask

    task automatic clear_all();
        pend = '0; prio = '0; grp = '0; nmi = '0; nact = '0; bpr = '0; run = 8'hFF;
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 / R8: reset and empty state
        chk("R8", "reset valid", 32'(wv), 0);
        chk("R8", "reset prio", 32'(wprio), 32'hFF);
        chk("R8", "reset id", 32'(wid), 0);
        chk("R3", "reset irq", 32'(irq), 0);

        // R3: reset threshold blocks even priority 0x00
        put(2, 8'h00, 0, 1'b0);
        step_model("R3");
        chk("R3", "mask0 blocks", 32'(irq), 0);
        chk("R3", "winner id", 32'(wid), 2);
        // R4: NMI bypasses the threshold
        nmi[2] = 1'b1;
        step_model("R4");
        chk("R4", "nmi bypass", 32'(irq), 1);

        // R2: full priority against threshold, split point ignored
        set_mask(8'h80);
        nmi[2] = 1'b0; prio[2*8 +: 8] = 8'h80; bpr[0 +: 3] = 3'd7;
        step_model("R2");
        chk("R2", "0x80 vs 0x80 masked", 32'(irq), 0);
        prio[2*8 +: 8] = 8'h7F;
        step_model("R2");
        chk("R2", "0x7F passes", 32'(irq), 1);

        // R5 / R7: equal group priority never preempts
        set_mask(8'hFF);
        bpr[0 +: 3] = 3'd3; run = 8'h40; prio[2*8 +: 8] = 8'h4F;
        step_model("R5");
        chk("R5", "equal group blocked", 32'(irq), 0);
        prio[2*8 +: 8] = 8'h3F;
        step_model("R5");
        chk("R5", "lower group preempts", 32'(irq), 1);

        // R6: NMI with equal group priority
        prio[2*8 +: 8] = 8'h4F; nmi[2] = 1'b1; nact = 3'b000;
        step_model("R6");
        chk("R6", "nmi equal, flag clear", 32'(irq), 1);
        nact = 3'b001;
        step_model("R6");
        chk("R6", "nmi equal, flag set", 32'(irq), 0);
        nact = 3'b000; run = 8'h3F;
        step_model("R6");
        chk("R6", "nmi group above run", 32'(irq), 0);

        // R1: ties and ordering
        clear_all();
        put(3, 8'h20, 1, 1'b0); put(5, 8'h20, 1, 1'b0);
        step_model("R1");
        chk("R1", "full tie lower id", 32'(wid), 3);
        bpr[3 +: 3] = 3'd2; prio[3*8 +: 8] = 8'h22; prio[5*8 +: 8] = 8'h21;
        step_model("R1");
        chk("R1", "subpriority decides", 32'(wid), 5);
        // R7: group priority decides before full priority
        bpr[0 +: 3] = 3'd7; bpr[3 +: 3] = 3'd0;
        grp[3*GW +: GW] = 2'd0; prio[3*8 +: 8] = 8'hF0; prio[5*8 +: 8] = 8'h10;
        step_model("R7");
        chk("R7", "group beats full prio", 32'(wid), 3);
        put(6, 8'hFF, 2, 1'b1);
        step_model("R1");
        chk("R1", "nmi outranks", 32'(wid), 6);

        // R10: out-of-range tag ignored
        clear_all();
        put(0, 8'h00, 3, 1'b0); put(4, 8'h90, 0, 1'b0);
        step_model("R10");
        chk("R10", "bad tag skipped", 32'(wid), 4);

        // R8: blocked winner hides a passing loser
        clear_all();
        put(1, 8'h90, 0, 1'b1); put(6, 8'h10, 0, 1'b0); run = 8'h80;
        step_model("R8");
        chk("R8", "blocked winner id", 32'(wid), 1);
        chk("R8", "no request", 32'(irq), 0);

        // R9: one-cycle latency
        clear_all();
        @(negedge clk);
        put(7, 8'h05, 0, 1'b0);
        #1;
        chk("R9", "irq before edge", 32'(irq), 0);
        chk("R9", "valid before edge", 32'(wv), 0);
        step_model("R9");
        chk("R9", "irq after edge", 32'(irq), 1);

        // Random mix (R1, R2, R5, R6, R7, R10)
        for (int it = 0; it < 1500; it++) begin
            if (it % 60 == 0) set_mask(8'($urandom_range(0, 255)));
            for (int k = 0; k < N; k++) begin
                pend[k] = ($urandom_range(0, 2) != 0);
                nmi[k]  = ($urandom_range(0, 9) == 0);
                grp[k*GW +: GW] = GW'(($urandom_range(0, 15) == 0) ? 3 : $urandom_range(0, 2));
                if ($urandom_range(0, 1) == 0) prio[k*8 +: 8] = 8'($urandom_range(0, 255));
                else prio[k*8 +: 8] = 8'(($urandom_range(0, 7) << 4) | $urandom_range(0, 3));
            end
            for (int g = 0; g < G; g++) bpr[g*3 +: 3] = 3'($urandom_range(0, 7));
            nact = 3'($urandom_range(0, 7));
            run = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'(($urandom_range(0, 7) << 4));
            step_model("R1");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule